// File: doc/BRIEF.md
# Two-Wire Bus Acknowledge Decision Unit

This unit sits beside the shift register of a two-wire serial bus controller. It decides, once per received byte, whether the device drives an acknowledge in the ninth clock slot. When a byte completes, the unit looks at four things: whether the byte was an address or data byte, the device's current role, a programmable own address, and a software acknowledge enable. It then registers an ACK or NACK decision.

For address bytes seen as a slave, the unit compares the upper seven bits with the own address. It also recognises the all-zero broadcast address when broadcast acceptance is enabled. A successful match sets an addressed flag, which stays set until a stop condition or the next slave address byte. For data bytes, the unit acknowledges only in a receiving role: as a master receiver, or as a slave receiver that is currently addressed. Clearing the acknowledge enable takes the device off the bus for address recognition. Setting the enable again brings recognition back. During the ninth-bit window, the registered decision becomes a pull-low request for the SDA driver.

Top module: `twb_ack_unit`

## Requirements
- R1: While `ack_en` is 0, every completed byte yields `ack_dec`=0. A slave address byte received in that state also clears `addressed`.
- R2: A slave address byte is acknowledged (`ack_dec`=1, `addressed`=1) when `ack_en`=1 and its bits 7:1 equal `own_addr[7:1]`. Bit 0 of the byte is the read/write direction and is ignored in the comparison.
- R3: The slave address byte 8'h00 is acknowledged and sets `addressed` only when `own_addr[0]`=1. The byte 8'h01 (all-zero address with read direction) is never treated as a broadcast.
- R4: When `ack_en`=1, a data byte (`addr_phase`=0) with `is_rx`=1 is acknowledged if `is_master`=1, or if `addressed`=1 in slave role. Otherwise it gets a NACK.
- R5: A data byte received with `is_rx`=0 (either transmitter role) yields `ack_dec`=0.
- R6: `sda_low_req` is 1 exactly while `bit9_win`=1 and the registered decision is ACK.
- R7: `bus_stop` clears `addressed` and `ack_dec` on the next clock edge.
- R8: The decision and the `addressed` flag change only on the clock edge at which `byte_done`=1, and they are held until the next such edge or a stop.
- R9: An address byte completed in master role yields a NACK and leaves `addressed` unchanged.
- R10: After `ack_en` returns to 1, the own address is acknowledged again.
- R11: After reset, `ack_dec`, `addressed` and `sda_low_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_done | input | 1 | One-cycle strobe: eight bits of `rx_byte` complete |
| rx_byte | input | 8 | Received byte |
| addr_phase | input | 1 | 1 = byte is an address byte, 0 = data byte |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| is_rx | input | 1 | 1 = receiver, 0 = transmitter |
| own_addr | input | 8 | Own address in bits 7:1, broadcast accept in bit 0 |
| ack_en | input | 1 | Software acknowledge enable |
| bit9_win | input | 1 | High for the ninth clock slot |
| bus_stop | input | 1 | Stop condition detected |
| ack_dec | output | 1 | Registered ACK (1) / NACK (0) decision |
| addressed | output | 1 | Device is currently selected as slave |
| sda_low_req | output | 1 | Request to pull SDA low |

## Verification
A corrupted `addressed` flag does not show up on its own at the ports. It appears on the next slave-receive data byte, which is acknowledged or refused wrongly one clock after `byte_done`. For that reason, the stimulus sequence follows address bytes with data bytes in both the matched and the unmatched state. A wrong decision register shows up immediately on `sda_low_req` during the ninth-bit window. The bench checks that the decision is held stable across idle cycles and is cleared by a stop.

// File: rtl/twb_ack_unit.sv
module twb_ack_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic       addr_phase,
  input  logic       is_master,
  input  logic       is_rx,
  input  logic [7:0] own_addr,
  input  logic       ack_en,
  input  logic       bit9_win,
  input  logic       bus_stop,
  output logic       ack_dec,
  output logic       addressed,
  output logic       sda_low_req
);

  logic own_hit, bcast_hit, addr_ok, data_ok, ack_next;

  assign own_hit   = rx_byte[7:1] == own_addr[7:1];
  assign bcast_hit = (rx_byte == 8'h00) && own_addr[0];
  assign addr_ok   = !is_master && (own_hit || bcast_hit);
  assign data_ok   = is_rx && (is_master || addressed);
  assign ack_next  = ack_en && (addr_phase ? addr_ok : data_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_dec   <= 1'b0;
      addressed <= 1'b0;
    end else if (bus_stop) begin
      ack_dec   <= 1'b0;
      addressed <= 1'b0;
    end else if (byte_done) begin
      ack_dec <= ack_next;
      if (addr_phase && !is_master) addressed <= ack_next;
    end
  end

  assign sda_low_req = ack_dec && bit9_win;

endmodule

// File: rtl/twb_ack_unit_chk.sv
module twb_ack_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_done,
  input logic       addr_phase,
  input logic       is_master,
  input logic       is_rx,
  input logic       ack_en,
  input logic       bit9_win,
  input logic       bus_stop,
  input logic       ack_dec,
  input logic       addressed,
  input logic       sda_low_req
);

  p_no_ack_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !bus_stop && !ack_en |=> !ack_dec);

  p_tx_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !bus_stop && !addr_phase && !is_rx |=> !ack_dec);

  p_sda_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_req |-> bit9_win && ack_dec);

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !addressed && !ack_dec);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done && !bus_stop |=> $stable(ack_dec) && $stable(addressed));

  p_master_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !bus_stop && addr_phase && is_master |=> !ack_dec && $stable(addressed));

endmodule

bind twb_ack_unit twb_ack_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .addr_phase(addr_phase),
  .is_master(is_master), .is_rx(is_rx), .ack_en(ack_en), .bit9_win(bit9_win),
  .bus_stop(bus_stop), .ack_dec(ack_dec), .addressed(addressed),
  .sda_low_req(sda_low_req)
);

// File: tb/twb_ack_unit_bench.sv
module twb_ack_unit_bench;
  localparam int CLK_NS = 10;
  localparam int NV = 16;

  logic clk = 0, rst_n = 0;
  logic byte_done = 0, addr_phase = 0, is_master = 0, is_rx = 0;
  logic ack_en = 0, bit9_win = 0, bus_stop = 0;
  logic [7:0] rx_byte = 0, own_addr = 0;
  logic ack_dec, addressed, sda_low_req;
  int checks = 0, fails = 0;

  // {addr_phase, is_master, is_rx, ack_en, own_addr, rx_byte, exp_ack, exp_addressed}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b1,8'hA4,8'hA4,1'b1,1'b1}, // R2 own match write
    {1'b0,1'b0,1'b1,1'b1,8'hA4,8'h3C,1'b1,1'b1}, // R4 addressed slave rx
    {1'b0,1'b0,1'b0,1'b1,8'hA4,8'h3C,1'b0,1'b1}, // R5 slave tx
    {1'b1,1'b0,1'b1,1'b1,8'hA4,8'hA5,1'b1,1'b1}, // R2 read direction
    {1'b1,1'b0,1'b1,1'b1,8'hA4,8'hA6,1'b0,1'b0}, // R2 mismatch
    {1'b0,1'b0,1'b1,1'b1,8'hA4,8'h55,1'b0,1'b0}, // R4 not addressed
    {1'b1,1'b0,1'b1,1'b1,8'hA4,8'h00,1'b0,1'b0}, // R3 broadcast disabled
    {1'b1,1'b0,1'b1,1'b1,8'hA5,8'h00,1'b1,1'b1}, // R3 broadcast enabled
    {1'b1,1'b0,1'b1,1'b1,8'hA5,8'h01,1'b0,1'b0}, // R3 zero addr read
    {1'b1,1'b0,1'b1,1'b0,8'hA4,8'hA4,1'b0,1'b0}, // R1 own addr ignored
    {1'b0,1'b0,1'b1,1'b0,8'hA4,8'h11,1'b0,1'b0}, // R1 data
    {1'b1,1'b0,1'b1,1'b1,8'hA4,8'hA4,1'b1,1'b1}, // R10 resumed
    {1'b0,1'b1,1'b1,1'b1,8'hA4,8'h22,1'b1,1'b1}, // R4 master rx
    {1'b0,1'b1,1'b0,1'b1,8'hA4,8'h22,1'b0,1'b1}, // R5 master tx
    {1'b1,1'b1,1'b0,1'b1,8'hA4,8'hA4,1'b0,1'b1}, // R9 master address
    {1'b0,1'b0,1'b1,1'b0,8'hA4,8'h77,1'b0,1'b1}  // R1 data, flag kept
  };

  twb_ack_unit u_twb_ack_unit (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .addr_phase(addr_phase), .is_master(is_master), .is_rx(is_rx),
    .own_addr(own_addr), .ack_en(ack_en), .bit9_win(bit9_win),
    .bus_stop(bus_stop), .ack_dec(ack_dec), .addressed(addressed),
    .sda_low_req(sda_low_req)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input logic [21:0] v);
    @(negedge clk);
    {addr_phase, is_master, is_rx, ack_en, own_addr, rx_byte} = v[21:2];
    byte_done = 1;
    @(negedge clk);
    byte_done = 0;
  endtask

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 ack", ack_dec, 1'b0);
    check("R11 addressed", addressed, 1'b0);
    check("R11 sda", sda_low_req, 1'b0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      check($sformatf("vector %0d ack (R1..R10 table)", i), ack_dec, VEC[i][1]);
      check($sformatf("vector %0d addressed (R1..R10 table)", i), addressed, VEC[i][0]);
    end

    send({1'b1,1'b0,1'b1,1'b1,8'hA4,8'hA4,1'b1,1'b1});
    rx_byte = 8'h00; addr_phase = 0; is_rx = 0;
    repeat (3) @(negedge clk);
    check("R8 ack held", ack_dec, 1'b1);
    check("R8 addressed held", addressed, 1'b1);
    check("R6 sda idle outside window", sda_low_req, 1'b0);
    bit9_win = 1;
    #1 check("R6 sda low in window", sda_low_req, 1'b1);
    @(negedge clk); bit9_win = 0;
    #1 check("R6 sda released", sda_low_req, 1'b0);

    bus_stop = 1;
    @(negedge clk); bus_stop = 0;
    check("R7 stop clears ack", ack_dec, 1'b0);
    check("R7 stop clears addressed", addressed, 1'b0);
    bit9_win = 1;
    #1 check("R6 nack keeps sda released", sda_low_req, 1'b0);
    bit9_win = 0;

    send({1'b0,1'b0,1'b1,1'b1,8'hA4,8'h12,1'b0,1'b0});
    check("R4 after stop not addressed", ack_dec, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule